// File: doc/BRIEF.md
# Exception Priority Masking Unit

This block decides, once per cycle, whether the exception candidate at its inputs may preempt the core. It keeps three pieces of masking state: a one-bit global disable, a one-bit fault mask and a priority threshold. It combines them with the candidate's priority and with two flags that mark the candidate as a non-maskable interrupt or as a hard fault. The result is a registered take/block decision. Lower priority values are more urgent. Only the upper `IMPL_W` bits of an 8-bit priority are implemented. Those bits are stored and compared, and the low bits are dropped.

Software reaches the state through write strobes that take effect only while the privilege flag is high. The threshold has two write ports. The plain port writes any value. The raise-only port changes the threshold only when the new value masks more. An exception-return strobe clears the fault mask by hardware.

Top module: `excp_mask_unit`

## Requirements
- R1: While the global disable is 1 and the fault mask is 0, a valid candidate that is neither NMI nor hard fault is blocked (take 0). A valid NMI or hard-fault candidate is taken.
- R2: While the fault mask is 1, every valid candidate except an NMI is blocked, hard fault included.
- R3: `exc_ret_i` clears the fault mask at the next edge. This holds in any privilege state, and it overrides a fault-mask write in the same cycle.
- R4: While `priv_i` is 0, writes on `gdis_we_i`, `fmask_we_i`, `thr_we_i` and `thr_raise_we_i` are ignored, and `gdis_o`, `fmask_o` and `thr_o` keep their values.
- R5: With a nonzero threshold, a valid ordinary candidate whose implemented priority bits are equal to or greater than the threshold's is blocked. Lower values are taken, subject to R1 and R2. A zero threshold blocks nothing.
- R6: A raise-only write is accepted only if its implemented bits are nonzero and either the held threshold is zero or the new bits are smaller. Otherwise it is ignored. For example, with 0x60 held, 0xF0 and 0x10 are ignored and 0x40 is accepted.
- R7: A plain threshold write stores any value, including 0 and values that mask less. When both ports write in the same cycle, the plain write wins.
- R8: Only the upper `IMPL_W` bits (bits 7:5 by default) of the threshold are stored, and `thr_o` reads its low bits as 0. The decision ignores the candidate's low bits too, so with threshold 0x60, priority 0x7F is blocked and 0x5F is taken.
- R9: `take_o` is registered. It shows the decision for the inputs and mask state of the previous cycle, and it is 0 when `cand_valid_i` was 0. After reset, all mask state and `take_o` are 0.
- R10: A valid NMI candidate is always taken, whatever the mask state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| priv_i | input | 1 | 1 = privileged; enables mask writes |
| gdis_we_i | input | 1 | Global disable write strobe |
| gdis_wd_i | input | 1 | Global disable write value |
| fmask_we_i | input | 1 | Fault mask write strobe |
| fmask_wd_i | input | 1 | Fault mask write value |
| thr_we_i | input | 1 | Plain threshold write strobe |
| thr_wd_i | input | PRIO_W | Plain threshold write value |
| thr_raise_we_i | input | 1 | Raise-only threshold write strobe |
| thr_raise_wd_i | input | PRIO_W | Raise-only threshold write value |
| exc_ret_i | input | 1 | Exception-return strobe |
| cand_valid_i | input | 1 | A candidate is presented |
| cand_nmi_i | input | 1 | Candidate is a non-maskable interrupt |
| cand_hf_i | input | 1 | Candidate is a hard fault |
| cand_prio_i | input | PRIO_W | Candidate priority (lower = more urgent) |
| take_o | output | 1 | Registered take decision |
| gdis_o | output | 1 | Current global disable |
| fmask_o | output | 1 | Current fault mask |
| thr_o | output | PRIO_W | Current threshold, low bits 0 |

## Verification
The assertions assume that all inputs are two-state and stay stable around the rising edge. They also assume that `cand_nmi_i` and `cand_hf_i` matter only while `cand_valid_i` is 1. An NMI and a hard fault may both be flagged at once, and NMI handling then governs. The bench drives every input on the falling edge with known values. It mixes directed sequences with random stimulus in which privilege is mostly high, exception returns are rare and priorities cover the full 8-bit range. Because low priority bits are included, the truncation is exercised along with the comparison.

// File: rtl/pmask_pkg.sv
package pmask_pkg;

    localparam int PRIO_W_DEF = 8;
    localparam int IMPL_W_DEF = 3;

    typedef struct packed {
        logic gdis;
        logic fmask;
    } mask_bits_t;

    typedef struct packed {
        logic valid;
        logic nmi;
        logic hard_fault;
    } cand_kind_t;

    typedef enum logic [2:0] {
        DEC_IDLE,
        DEC_NMI,
        DEC_HF,
        DEC_BLK_FAULT,
        DEC_BLK_GLOBAL,
        DEC_BLK_THRESH,
        DEC_TAKE
    } decision_t;

    function automatic logic decision_is_take(decision_t d);
        return (d == DEC_NMI) || (d == DEC_HF) || (d == DEC_TAKE);
    endfunction

    function automatic logic fault_mask_next(logic cur, logic ret, logic we, logic wd);
        logic nxt;
        nxt = cur;
        if (we)  nxt = wd;
        if (ret) nxt = 1'b0;
        return nxt;
    endfunction

endpackage

// File: rtl/pm_mask_regs.sv
module pm_mask_regs
    import pmask_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       priv,
    input  logic       gdis_we,
    input  logic       gdis_wd,
    input  logic       fmask_we,
    input  logic       fmask_wd,
    input  logic       exc_ret,
    output mask_bits_t masks
);

    mask_bits_t masks_q;
    logic       gdis_accept;
    logic       fmask_accept;

    assign gdis_accept  = priv & gdis_we;
    assign fmask_accept = priv & fmask_we;

    always_ff @(posedge clk) begin
        if (rst) begin
            masks_q <= '0;
        end else begin
            if (gdis_accept) masks_q.gdis <= gdis_wd;
            masks_q.fmask <= fault_mask_next(masks_q.fmask, exc_ret, fmask_accept, fmask_wd);
        end
    end

    assign masks = masks_q;

endmodule

// File: rtl/pm_thresh_reg.sv
module pm_thresh_reg #(
    parameter int PRIO_W = 8,
    parameter int IMPL_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              priv,
    input  logic              wr_we,
    input  logic [PRIO_W-1:0] wr_data,
    input  logic              raise_we,
    input  logic [PRIO_W-1:0] raise_data,
    output logic [IMPL_W-1:0] thr_hi,
    output logic [PRIO_W-1:0] thr_full
);

    localparam int LOW_W = PRIO_W - IMPL_W;

    logic [IMPL_W-1:0] thr_q;
    logic [IMPL_W-1:0] wr_hi;
    logic [IMPL_W-1:0] raise_hi;
    logic              raise_ok;

    assign wr_hi    = wr_data[PRIO_W-1 -: IMPL_W];
    assign raise_hi = raise_data[PRIO_W-1 -: IMPL_W];

    // Raise-only: new level must be nonzero and more urgent than a held one.
    assign raise_ok = (raise_hi != '0) && ((thr_q == '0) || (raise_hi < thr_q));

    always_ff @(posedge clk) begin
        if (rst) begin
            thr_q <= '0;
        end else if (priv) begin
            if (wr_we)
                thr_q <= wr_hi;
            else if (raise_we && raise_ok)
                thr_q <= raise_hi;
        end
    end

    assign thr_hi = thr_q;

    generate
        if (LOW_W > 0) begin : g_pad
            assign thr_full = {thr_q, {LOW_W{1'b0}}};
        end else begin : g_full
            assign thr_full = thr_q;
        end
    endgenerate

endmodule

// File: rtl/pm_decide.sv
module pm_decide
    import pmask_pkg::*;
#(
    parameter int PRIO_W = 8,
    parameter int IMPL_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  mask_bits_t        masks,
    input  logic [IMPL_W-1:0] thr_hi,
    input  cand_kind_t        kind,
    input  logic [PRIO_W-1:0] prio,
    output logic              take
);

    logic [IMPL_W-1:0] prio_hi;
    logic              thr_hit;
    decision_t         dec;
    logic              take_q;

    assign prio_hi = prio[PRIO_W-1 -: IMPL_W];
    assign thr_hit = (thr_hi != '0) && (prio_hi >= thr_hi);

    always_comb begin
        if (!kind.valid)              dec = DEC_IDLE;
        else if (kind.nmi)            dec = DEC_NMI;
        else if (masks.fmask)         dec = DEC_BLK_FAULT;
        else if (kind.hard_fault)     dec = DEC_HF;
        else if (masks.gdis)          dec = DEC_BLK_GLOBAL;
        else if (thr_hit)             dec = DEC_BLK_THRESH;
        else                          dec = DEC_TAKE;
    end

    always_ff @(posedge clk) begin
        if (rst) take_q <= 1'b0;
        else     take_q <= decision_is_take(dec);
    end

    assign take = take_q;

endmodule

// File: rtl/excp_mask_unit.sv
module excp_mask_unit
    import pmask_pkg::*;
#(
    parameter int PRIO_W = PRIO_W_DEF,
    parameter int IMPL_W = IMPL_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              priv_i,
    input  logic              gdis_we_i,
    input  logic              gdis_wd_i,
    input  logic              fmask_we_i,
    input  logic              fmask_wd_i,
    input  logic              thr_we_i,
    input  logic [PRIO_W-1:0] thr_wd_i,
    input  logic              thr_raise_we_i,
    input  logic [PRIO_W-1:0] thr_raise_wd_i,
    input  logic              exc_ret_i,
    input  logic              cand_valid_i,
    input  logic              cand_nmi_i,
    input  logic              cand_hf_i,
    input  logic [PRIO_W-1:0] cand_prio_i,
    output logic              take_o,
    output logic              gdis_o,
    output logic              fmask_o,
    output logic [PRIO_W-1:0] thr_o
);

    mask_bits_t        masks;
    logic [IMPL_W-1:0] thr_hi;
    cand_kind_t        kind;

    assign kind = '{valid: cand_valid_i, nmi: cand_nmi_i, hard_fault: cand_hf_i};

    pm_mask_regs u_masks (
        .clk      (clk),
        .rst      (rst),
        .priv     (priv_i),
        .gdis_we  (gdis_we_i),
        .gdis_wd  (gdis_wd_i),
        .fmask_we (fmask_we_i),
        .fmask_wd (fmask_wd_i),
        .exc_ret  (exc_ret_i),
        .masks    (masks)
    );

    pm_thresh_reg #(.PRIO_W(PRIO_W), .IMPL_W(IMPL_W)) u_thr (
        .clk        (clk),
        .rst        (rst),
        .priv       (priv_i),
        .wr_we      (thr_we_i),
        .wr_data    (thr_wd_i),
        .raise_we   (thr_raise_we_i),
        .raise_data (thr_raise_wd_i),
        .thr_hi     (thr_hi),
        .thr_full   (thr_o)
    );

    pm_decide #(.PRIO_W(PRIO_W), .IMPL_W(IMPL_W)) u_dec (
        .clk    (clk),
        .rst    (rst),
        .masks  (masks),
        .thr_hi (thr_hi),
        .kind   (kind),
        .prio   (cand_prio_i),
        .take   (take_o)
    );

    assign gdis_o  = masks.gdis;
    assign fmask_o = masks.fmask;

endmodule

// File: rtl/excp_mask_unit_chk.sv
module excp_mask_unit_chk #(
    parameter int PRIO_W = 8,
    parameter int IMPL_W = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              priv_i,
    input logic              gdis_we_i,
    input logic              fmask_we_i,
    input logic              thr_we_i,
    input logic              thr_raise_we_i,
    input logic [PRIO_W-1:0] thr_raise_wd_i,
    input logic              exc_ret_i,
    input logic              cand_valid_i,
    input logic              cand_nmi_i,
    input logic              cand_hf_i,
    input logic [PRIO_W-1:0] cand_prio_i,
    input logic              take_o,
    input logic              gdis_o,
    input logic              fmask_o,
    input logic [PRIO_W-1:0] thr_o
);

    logic [IMPL_W-1:0] c_raise_hi;
    logic [IMPL_W-1:0] c_thr_hi;
    logic [IMPL_W-1:0] c_prio_hi;
    logic              c_ordinary;

    assign c_raise_hi = thr_raise_wd_i[PRIO_W-1 -: IMPL_W];
    assign c_thr_hi   = thr_o[PRIO_W-1 -: IMPL_W];
    assign c_prio_hi  = cand_prio_i[PRIO_W-1 -: IMPL_W];
    assign c_ordinary = cand_valid_i && !cand_nmi_i && !cand_hf_i;

    a_r1_global_blocks: assert property (@(posedge clk) disable iff (rst)
        (c_ordinary && gdis_o) |=> !take_o);

    a_r1_hf_passes_global: assert property (@(posedge clk) disable iff (rst)
        (cand_valid_i && cand_hf_i && !fmask_o) |=> take_o);

    a_r2_fault_blocks: assert property (@(posedge clk) disable iff (rst)
        (cand_valid_i && !cand_nmi_i && fmask_o) |=> !take_o);

    a_r3_return_clears: assert property (@(posedge clk) disable iff (rst)
        exc_ret_i |=> !fmask_o);

    a_r4_unpriv_gdis: assert property (@(posedge clk) disable iff (rst)
        !priv_i |=> $stable(gdis_o));

    a_r4_unpriv_thr: assert property (@(posedge clk) disable iff (rst)
        !priv_i |=> $stable(thr_o));

    a_r4_unpriv_fmask: assert property (@(posedge clk) disable iff (rst)
        (!priv_i && !exc_ret_i) |=> $stable(fmask_o));

    a_r5_thresh_blocks: assert property (@(posedge clk) disable iff (rst)
        (c_ordinary && c_thr_hi != '0 && c_prio_hi >= c_thr_hi) |=> !take_o);

    a_r6_raise_rejected: assert property (@(posedge clk) disable iff (rst)
        (priv_i && thr_raise_we_i && !thr_we_i &&
         (c_raise_hi == '0 || (c_thr_hi != '0 && c_raise_hi >= c_thr_hi)))
        |=> $stable(thr_o));

    a_r6_raise_accepted: assert property (@(posedge clk) disable iff (rst)
        (priv_i && thr_raise_we_i && !thr_we_i && c_raise_hi != '0 &&
         (c_thr_hi == '0 || c_raise_hi < c_thr_hi))
        |=> (thr_o[PRIO_W-1 -: IMPL_W] == $past(c_raise_hi)));

    a_r9_idle_no_take: assert property (@(posedge clk) disable iff (rst)
        !cand_valid_i |=> !take_o);

    a_r10_nmi_taken: assert property (@(posedge clk) disable iff (rst)
        (cand_valid_i && cand_nmi_i) |=> take_o);

endmodule

bind excp_mask_unit excp_mask_unit_chk #(.PRIO_W(PRIO_W), .IMPL_W(IMPL_W)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .priv_i         (priv_i),
    .gdis_we_i      (gdis_we_i),
    .fmask_we_i     (fmask_we_i),
    .thr_we_i       (thr_we_i),
    .thr_raise_we_i (thr_raise_we_i),
    .thr_raise_wd_i (thr_raise_wd_i),
    .exc_ret_i      (exc_ret_i),
    .cand_valid_i   (cand_valid_i),
    .cand_nmi_i     (cand_nmi_i),
    .cand_hf_i      (cand_hf_i),
    .cand_prio_i    (cand_prio_i),
    .take_o         (take_o),
    .gdis_o         (gdis_o),
    .fmask_o        (fmask_o),
    .thr_o          (thr_o)
);

// File: tb/sim_excp_mask_unit.sv
module sim_excp_mask_unit;

    localparam int SH = 5;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       priv_i = 0, gdis_we_i = 0, gdis_wd_i = 0, fmask_we_i = 0, fmask_wd_i = 0;
    logic       thr_we_i = 0, thr_raise_we_i = 0, exc_ret_i = 0;
    logic [7:0] thr_wd_i = 0, thr_raise_wd_i = 0, cand_prio_i = 0;
    logic       cand_valid_i = 0, cand_nmi_i = 0, cand_hf_i = 0;
    logic       take_o, gdis_o, fmask_o;
    logic [7:0] thr_o;

    always #2 clk = ~clk;

    excp_mask_unit u0 (.*);

    int checks = 0;
    int failures = 0;

    // Reference state
    int m_gd = 0, m_fm = 0, m_thr = 0, e_take = 0;
    string prev_tag = "R9";

    // Staged stimulus
    int n_priv, n_gwe, n_gwd, n_fwe, n_fwd, n_twe, n_twd, n_rwe, n_rwd, n_ret;
    int n_val, n_nmi, n_hf, n_prio;

    task automatic clr_nx();
        n_priv = 1; n_gwe = 0; n_gwd = 0; n_fwe = 0; n_fwd = 0; n_twe = 0; n_twd = 0;
        n_rwe = 0; n_rwd = 0; n_ret = 0; n_val = 0; n_nmi = 0; n_hf = 0; n_prio = 0;
    endtask

    task automatic cmp(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d t=%0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic step(string tag);
        @(negedge clk);
        cmp(prev_tag, "take", int'(take_o), e_take);
        cmp(prev_tag, "gdis", int'(gdis_o), m_gd);
        cmp(prev_tag, "fmask", int'(fmask_o), m_fm);
        cmp(prev_tag, "thr", int'(thr_o), m_thr << SH);
        priv_i = n_priv[0]; gdis_we_i = n_gwe[0]; gdis_wd_i = n_gwd[0];
        fmask_we_i = n_fwe[0]; fmask_wd_i = n_fwd[0];
        thr_we_i = n_twe[0]; thr_wd_i = n_twd[7:0];
        thr_raise_we_i = n_rwe[0]; thr_raise_wd_i = n_rwd[7:0];
        exc_ret_i = n_ret[0]; cand_valid_i = n_val[0]; cand_nmi_i = n_nmi[0];
        cand_hf_i = n_hf[0]; cand_prio_i = n_prio[7:0];
        // decision from current state
        if (n_val == 0) e_take = 0;
        else if (n_nmi != 0) e_take = 1;
        else if (m_fm != 0) e_take = 0;
        else if (n_hf != 0) e_take = 1;
        else if (m_gd != 0) e_take = 0;
        else if (m_thr != 0 && ((n_prio & 255) >> SH) >= m_thr) e_take = 0;
        else e_take = 1;
        // state update
        if (n_priv != 0) begin
            if (n_gwe != 0) m_gd = n_gwd & 1;
            if (n_fwe != 0) m_fm = n_fwd & 1;
            if (n_twe != 0) m_thr = (n_twd & 255) >> SH;
            else if (n_rwe != 0 && ((n_rwd & 255) >> SH) != 0 &&
                     (m_thr == 0 || ((n_rwd & 255) >> SH) < m_thr))
                m_thr = (n_rwd & 255) >> SH;
        end
        if (n_ret != 0) m_fm = 0;
        prev_tag = tag;
        clr_nx();
    endtask

    task automatic cand(string tag, int prio, int nmi, int hf);
        n_val = 1; n_prio = prio; n_nmi = nmi; n_hf = hf;
        step(tag);
    endtask

    initial begin
        #400000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        clr_nx();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        step("R9");                       // reset values checked at the next step
        cand("R9", 8'hFF, 0, 0);          // open candidate -> taken
        step("R9");                       // idle -> no take
        // R5 / R8 threshold
        n_twe = 1; n_twd = 8'h60; step("R5");
        cand("R5", 8'h60, 0, 0);
        cand("R8", 8'h5F, 0, 0);
        cand("R8", 8'h7F, 0, 0);
        cand("R5", 8'hFF, 0, 0);
        cand("R5", 8'h00, 0, 0);
        // R6 raise-only port
        n_rwe = 1; n_rwd = 8'hF0; step("R6");
        n_rwe = 1; n_rwd = 8'h10; step("R6");
        n_rwe = 1; n_rwd = 8'h40; step("R6");
        cand("R6", 8'h5F, 0, 0);
        // R7 plain write lowers and wins
        n_twe = 1; n_twd = 8'hE0; step("R7");
        n_twe = 1; n_twd = 8'hC0; n_rwe = 1; n_rwd = 8'h20; step("R7");
        n_twe = 1; n_twd = 8'h00; step("R7");
        n_rwe = 1; n_rwd = 8'hA5; step("R6");
        cand("R5", 8'hFF, 0, 0);
        n_twe = 1; n_twd = 8'h00; step("R7");
        cand("R5", 8'hFF, 0, 0);
        // R4 unprivileged writes
        n_priv = 0; n_gwe = 1; n_gwd = 1; n_fwe = 1; n_fwd = 1; n_twe = 1; n_twd = 8'h20; step("R4");
        n_priv = 0; n_rwe = 1; n_rwd = 8'h20; step("R4");
        cand("R4", 8'hFF, 0, 0);
        // R1 global disable
        n_gwe = 1; n_gwd = 1; step("R1");
        cand("R1", 8'h00, 0, 0);
        cand("R1", 8'h80, 0, 1);
        cand("R10", 8'h80, 1, 0);
        // R2 fault mask
        n_fwe = 1; n_fwd = 1; step("R2");
        cand("R2", 8'h00, 0, 1);
        cand("R10", 8'hFF, 1, 0);
        cand("R2", 8'h00, 0, 0);
        // R3 exception return
        n_ret = 1; n_priv = 0; step("R3");
        n_fwe = 1; n_fwd = 1; step("R3");
        n_ret = 1; n_fwe = 1; n_fwd = 1; step("R3");
        n_gwe = 1; n_gwd = 0; step("R1");
        cand("R3", 8'h00, 0, 1);
        // random phase
        for (int i = 0; i < 3000; i++) begin
            n_priv = ($urandom_range(0, 9) != 0);
            n_gwe = ($urandom_range(0, 15) == 0); n_gwd = $urandom_range(0, 1);
            n_fwe = ($urandom_range(0, 15) == 0); n_fwd = $urandom_range(0, 1);
            n_twe = ($urandom_range(0, 11) == 0); n_twd = $urandom_range(0, 255);
            n_rwe = ($urandom_range(0, 5) == 0);  n_rwd = $urandom_range(0, 255);
            n_ret = ($urandom_range(0, 19) == 0);
            n_val = ($urandom_range(0, 3) != 0);
            n_nmi = ($urandom_range(0, 15) == 0); n_hf = ($urandom_range(0, 9) == 0);
            n_prio = $urandom_range(0, 255);
            step("R5");
        end
        step("R9");
        step("R9");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule